// File: doc/BRIEF.md
# Five-Channel Rate-Stretched PWM DAC

This block drives five pulse-width outputs from one shared time base, each meant to be smoothed by an external low-pass filter into an analog level. A prescaler divides the system clock into slots. The slot length is picked by a 2-bit divider select. Thirty-two slots make one period, and eight periods make one frame.

Each channel takes an 8-bit word. The upper five bits give the coarse high time in slots. The lower three bits choose which periods of the frame get one extra high slot. Averaged over a frame, this gives 256 output levels, yet the output still repeats at the 32-slot rate.

A channel copies its word only at a frame boundary, so one frame never mixes two settings. When a channel's enable is low, its pin carries a plain GPIO value instead of the waveform.

Top module: `hybrid_pwm_dac`

## Requirements
- R1: After reset the word held by every channel is 0, so an enabled channel drives 0 until the first frame boundary loads its input word.
- R2: One slot lasts 2^(div_sel+1) system clocks: 2, 4, 8 or 16 for div_sel 0, 1, 2, 3.
- R3: A period is 32 slots. An enabled channel is high for the first C slots of the period and low for the rest, where C is word bits 7:3.
- R4: Periods of a frame are numbered 0 to 7. Word bit 2 adds one high slot in periods 1, 3, 5 and 7. Word bit 1 adds one in periods 2 and 6. Word bit 0 adds one in period 4. Period 0 is never stretched.
- R5: Over one whole frame, an enabled channel is high for exactly slot_len × (8·C + F) system clocks, where F is word bits 2:0.
- R6: A channel loads its input word only on the clock edge that ends slot 31 of period 7. A word change at any other time has no effect until that edge.
- R7: While a channel's enable is 0, its pin equals its GPIO input in the same cycle.
- R8: A word of 0xFF keeps the pin high for every slot of the frame except the last slot of period 0. A word of 0x00 keeps it low for the whole frame.
- R9: All channels share one slot counter, so their periods and frames start on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Slot length select, 2^(div_sel+1) clocks |
| duty_words | input | 40 | Channel words; channel i at bits 8i+7:8i |
| chan_en | input | 5 | Per-channel waveform enable |
| gpio_val | input | 5 | Per-channel fallback level |
| pwm_pin | output | 5 | Per-channel output pin |

## Verification
The pin is a combinational function of registered state plus the enable and GPIO inputs, so an enable or GPIO change appears in the same cycle. A new word shows on the pin in the first clock after the frame-ending edge, and each slot edge moves the waveform on the clock after the prescaler's last count.

The bench steps a behavioural reference model on the same rising edge as the design. It compares every pin 2 ns after that edge, once the registered state has settled and before any input changes at the falling edge.

Frame-level totals are taken only over frames that start after the word or divider last changed. No measured frame straddles a word load or a change of slot length.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
  localparam int DEF_CH       = 5;
  localparam int DEF_COARSE_W = 5;
  localparam int DEF_FINE_W   = 3;
  localparam int DEF_DIV_W    = 2;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int CNT_W = 1 << DIV_W;
  localparam logic [DIV_W:0] SH_ONE  = 1;
  localparam logic [CNT_W:0] LIM_ONE = 1;
  localparam logic [CNT_W:0] BASE    = 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   limit;
  logic [DIV_W:0]   shift_amt;

  always_comb begin
    shift_amt = {1'b0, div_sel} + SH_ONE;
    limit     = (BASE << shift_amt) - LIM_ONE;
    tick      = ({1'b0, cnt_q} >= limit);
    cnt_d     = tick ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  output logic [COARSE_W-1:0] slot,
  output logic [FINE_W-1:0]   period,
  output logic                frame_end
);
  logic [COARSE_W-1:0] slot_q, slot_d;
  logic [FINE_W-1:0]   per_q, per_d;
  logic                slot_last, per_last;

  always_comb begin
    slot_last = &slot_q;
    per_last  = &per_q;
    slot_d    = slot_q;
    per_d     = per_q;
    if (tick) begin
      slot_d = slot_q + COARSE_W'(1);
      if (slot_last) per_d = per_q + FINE_W'(1);
    end
    frame_end = tick & slot_last & per_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      per_q  <= '0;
    end else begin
      slot_q <= slot_d;
      per_q  <= per_d;
    end
  end

  assign slot   = slot_q;
  assign period = per_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 3,
  localparam int WORD_W  = COARSE_W + FINE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_end,
  input  logic [COARSE_W-1:0] slot,
  input  logic [FINE_W-1:0]   period,
  input  logic [WORD_W-1:0]   word_in,
  input  logic                en,
  input  logic                gpio,
  output logic [WORD_W-1:0]   held,
  output logic                pin
);
  logic [WORD_W-1:0]   held_q, held_d;
  logic [COARSE_W-1:0] coarse;
  logic [FINE_W-1:0]   fine;
  logic                stretch, found, level;
  logic [COARSE_W:0]   high_len;

  always_comb begin
    held_d = frame_end ? word_in : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  // The lowest set bit of the period index picks the fine bit:
  // bit position k selects fine bit FINE_W-1-k, and period 0 picks none.
  always_comb begin
    coarse  = held_q[WORD_W-1:FINE_W];
    fine    = held_q[FINE_W-1:0];
    stretch = 1'b0;
    found   = 1'b0;
    for (int k = 0; k < FINE_W; k++) begin
      if (!found && period[k]) begin
        stretch = fine[FINE_W-1-k];
        found   = 1'b1;
      end
    end
    high_len = {1'b0, coarse} + {{COARSE_W{1'b0}}, stretch};
    level    = ({1'b0, slot} < high_len);
    pin      = en ? level : gpio;
  end

  assign held = held_q;
endmodule

// File: rtl/hybrid_pwm_dac.sv
module hybrid_pwm_dac
  import pwm_dac_pkg::*;
#(
  parameter int NUM_CH   = DEF_CH,
  parameter int COARSE_W = DEF_COARSE_W,
  parameter int FINE_W   = DEF_FINE_W,
  parameter int DIV_W    = DEF_DIV_W,
  localparam int WORD_W  = COARSE_W + FINE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DIV_W-1:0]         div_sel,
  input  logic [NUM_CH*WORD_W-1:0] duty_words,
  input  logic [NUM_CH-1:0]        chan_en,
  input  logic [NUM_CH-1:0]        gpio_val,
  output logic [NUM_CH-1:0]        pwm_pin
);
  logic                     slot_tick;
  logic [COARSE_W-1:0]      slot_idx;
  logic [FINE_W-1:0]        period_idx;
  logic                     frame_end;
  logic [NUM_CH*WORD_W-1:0] held_flat;

  pwm_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .tick    (slot_tick)
  );

  pwm_timebase #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_tbase (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (slot_tick),
    .slot      (slot_idx),
    .period    (period_idx),
    .frame_end (frame_end)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end),
      .slot      (slot_idx),
      .period    (period_idx),
      .word_in   (duty_words[g*WORD_W +: WORD_W]),
      .en        (chan_en[g]),
      .gpio      (gpio_val[g]),
      .held      (held_flat[g*WORD_W +: WORD_W]),
      .pin       (pwm_pin[g])
    );
  end
endmodule

// File: rtl/pwm_dac_chk.sv
module pwm_dac_chk #(
  parameter int NUM_CH   = 5,
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 3,
  localparam int WORD_W  = COARSE_W + FINE_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick,
  input logic [COARSE_W-1:0]      slot,
  input logic [FINE_W-1:0]        period,
  input logic                     frame_end,
  input logic [NUM_CH*WORD_W-1:0] held_flat,
  input logic [NUM_CH*WORD_W-1:0] duty_words,
  input logic [NUM_CH-1:0]        chan_en,
  input logic [NUM_CH-1:0]        pwm_pin
);
  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R3
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(slot));

  // R3
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && slot != '1) |=> slot == COARSE_W'($past(slot) + 1'b1));

  // R9
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (slot == '0 && period == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R6
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(held_flat[i*WORD_W +: WORD_W]));

    // R6
    held_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> held_flat[i*WORD_W +: WORD_W] == $past(duty_words[i*WORD_W +: WORD_W]));

    // R8
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en[i] && held_flat[i*WORD_W +: WORD_W] == '0) |-> !pwm_pin[i]);

    // R4
    period0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en[i] && period == '0 && slot >= held_flat[i*WORD_W+FINE_W +: COARSE_W])
      |-> !pwm_pin[i]);
  end
endmodule

bind hybrid_pwm_dac pwm_dac_chk #(
  .NUM_CH(NUM_CH), .COARSE_W(COARSE_W), .FINE_W(FINE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (slot_tick),
  .slot       (slot_idx),
  .period     (period_idx),
  .frame_end  (frame_end),
  .held_flat  (held_flat),
  .duty_words (duty_words),
  .chan_en    (chan_en),
  .pwm_pin    (pwm_pin)
);

// File: tb/hybrid_pwm_dac_tb.sv
module hybrid_pwm_dac_tb;
  localparam int NCH = 5;

  logic        clk;
  logic        rst_n;
  logic [1:0]  div_sel;
  logic [39:0] duty_words;
  logic [4:0]  chan_en;
  logic [4:0]  gpio_val;
  logic [4:0]  pwm_pin;

  int    n_cmp;
  int    n_bad;
  bit    done;
  bit    running;
  string phase;

  int m_pc, m_slot, m_period, frame_cnt, last_fc;
  logic [7:0] m_held [NCH];
  int hi_cnt [NCH];
  int frame_hi [NCH];

  hybrid_pwm_dac u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_sel    (div_sel),
    .duty_words (duty_words),
    .chan_en    (chan_en),
    .gpio_val   (gpio_val),
    .pwm_pin    (pwm_pin)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit ref_level(logic [7:0] w, int s, int p);
    int c = int'(w[7:3]);
    int x = 0;
    if ((p % 2) == 1 && w[2]) x = 1;
    if ((p % 4) == 2 && w[1]) x = 1;
    if (p == 4 && w[0]) x = 1;
    return s < c + x;
  endfunction

  // Behavioural reference model, stepped on the same edge as the design.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_slot = 0; m_period = 0; frame_cnt = 0;
      for (int i = 0; i < NCH; i++) m_held[i] = 8'h00;
    end else begin
      if (m_pc >= (2 << div_sel) - 1) begin
        m_pc = 0;
        if (m_slot == 31) begin
          m_slot = 0;
          if (m_period == 7) begin
            m_period = 0;
            for (int i = 0; i < NCH; i++) m_held[i] = duty_words[i*8 +: 8];
            frame_cnt = frame_cnt + 1;
          end else m_period = m_period + 1;
        end else m_slot = m_slot + 1;
      end else m_pc = m_pc + 1;
    end
  end

  // Per-cycle comparison, taken 2 ns after the edge.
  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      last_fc = 0;
      for (int i = 0; i < NCH; i++) begin hi_cnt[i] = 0; frame_hi[i] = 0; end
    end else if (running) begin
      if (frame_cnt != last_fc) begin
        for (int i = 0; i < NCH; i++) begin frame_hi[i] = hi_cnt[i]; hi_cnt[i] = 0; end
        last_fc = frame_cnt;
      end
      for (int i = 0; i < NCH; i++) begin
        bit e;
        e = chan_en[i] ? ref_level(m_held[i], m_slot, m_period) : gpio_val[i];
        hi_cnt[i] = hi_cnt[i] + int'(pwm_pin[i]);
        n_cmp++;
        if (pwm_pin[i] !== e) begin
          n_bad++;
          $display("FAIL %s ch%0d slot%0d period%0d: got %0b expected %0b",
                   phase, i, m_slot, m_period, pwm_pin[i], e);
        end
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic set_words(input logic [7:0] a, b, c, d, e);
    @(negedge clk);
    duty_words = {e, d, c, b, a};
  endtask

  // Waits out two boundaries so the measured frame is clean, then checks totals (R5).
  task automatic measure_frame(input string tag);
    int n;
    n = frame_cnt;
    wait (frame_cnt == n + 3);
    #3;
    for (int i = 0; i < NCH; i++) begin
      logic [7:0] w;
      int expv;
      w = duty_words[i*8 +: 8];
      expv = (2 << div_sel) * (8 * int'(w[7:3]) + int'(w[2:0]));
      chk($sformatf("%s ch%0d word %02h frame highs", tag, i, w), frame_hi[i], expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0; running = 1'b0;
    phase = "reset";
    rst_n = 1'b0;
    div_sel = 2'd0;
    duty_words = '0;
    chan_en = 5'b00000;
    gpio_val = 5'b10110;
    repeat (3) @(negedge clk);
    #1;
    chk("R7 pins follow gpio in reset", int'(pwm_pin), int'(5'b10110));
    chan_en = 5'b11111;
    #1;
    chk("R1 held words zero in reset", int'(pwm_pin), 0);
    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    phase = "R1 zero word before first frame";
    set_words(8'h83, 8'h00, 8'hFF, 8'h07, 8'h5C);
    wait (frame_cnt == 1);
    phase = "R3 R4 R8 coarse and stretched slots";
    measure_frame("R5 R8");

    wait (m_period == 3);
    phase = "R6 mid-frame write held off";
    set_words(8'h3A, 8'hF9, 8'h01, 8'hA4, 8'h12);
    phase = "R9 shared frame start";
    measure_frame("R5 R6 R9");

    for (int d = 1; d < 4; d++) begin
      @(negedge clk);
      div_sel = 2'(d);
      phase = $sformatf("R2 divider %0d", d);
      measure_frame("R2");
    end

    @(negedge clk);
    div_sel = 2'd0;
    phase = "R7 gpio fallback";
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      chan_en  = 5'(k * 7);
      gpio_val = 5'(k * 13 + 5);
      #1;
      for (int i = 0; i < NCH; i++)
        if (!chan_en[i]) chk($sformatf("R7 ch%0d disabled", i), int'(pwm_pin[i]), int'(gpio_val[i]));
    end

    @(negedge clk);
    chan_en = 5'b11111;
    repeat (20) @(negedge clk);
    running = 1'b0;
    finish_run();
  end
endmodule